// File: doc/BRIEF.md
# Histogram Template Matcher with Closest-Match Search

This block keeps a library of up to 32 colour-histogram signatures, each made of 36 bins of 12 bits. A histogram enters one bin per clock on a simple valid/data stream. The learn flag and slot number that arrive with the first bin decide what happens to the histogram. In learn mode the bins are written into the chosen slot, and the slot is marked as holding a signature. In recognition mode the histogram is kept in a local buffer. That buffer is then replayed once for each group of four slots, and the four slots of the group are scored at the same time by the sum of absolute bin differences.

The 32 slots form 8 groups of 4. A slot number is the group index times 4 plus the lane index, so the lane sits in the two low bits and the group in the three high bits. After the last group the block reports the closest signature on its outputs: the slot index and its score. A no-match flag is raised instead when the library is empty. The outputs are registered and hold until the next search ends.

Top module: `hist_sad_matcher`

## Requirements
- R1: A histogram whose first bin comes with `learn_in`=1 is stored, all 36 bins, into the slot given by `slot_in` on that first bin (slot = group*4 + lane). That slot then takes part in later searches. The values of `learn_in` and `slot_in` on bins 2 to 36 are not used.
- R2: In recognition mode, the score of a slot is the sum over the 36 bins of |input bin − stored bin|. The score is reported on the 18-bit `match_sad`, and it is exact up to its largest value of 36*4095 = 147420.
- R3: `match_idx` and `match_sad` report the stored slot with the smallest score among the slots that hold a signature.
- R4: When scores are equal, the lower slot index wins. This holds both inside a group and across groups.
- R5: A slot that has never been learned takes no part in the search. When no slot holds a signature, the result is `no_match`=1, `match_idx`=0 and `match_sad`=262143 (all ones). Otherwise `no_match`=0.
- R6: `done` is a one-cycle pulse. It is high in the cycle after the 290th rising edge (8*36+2) that follows the edge that accepted the last bin of a recognition histogram. The result outputs change only at that edge and then hold.
- R7: `busy` goes high at the edge that accepts the last bin of a recognition histogram and goes low at the edge that raises `done`. Bins offered while `busy` is high are ignored: they are not counted, not stored and not learned.
- R8: After a synchronous reset, `done`, `busy`, `no_match`, `match_idx` and `match_sad` are all 0, and no slot holds a signature.
- R9: Learning never raises `busy` or `done`. Learning into a slot that is already used replaces its old signature.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bin_valid | input | 1 | A histogram bin is offered this cycle |
| bin_data | input | 12 | Bin count |
| learn_in | input | 1 | Mode for the histogram, sampled with its first bin (1 = learn) |
| slot_in | input | 5 | Target slot for learning, sampled with the first bin |
| busy | output | 1 | A search is running and input bins are ignored |
| done | output | 1 | One-cycle pulse when a search result is posted |
| no_match | output | 1 | The last search found no learned slot |
| match_idx | output | 5 | Slot with the smallest score |
| match_sad | output | 18 | Score of that slot |

## Verification
Some properties are checked on every cycle: `done` never lasts two cycles, a result is only posted at the end of a busy period, an empty search always posts the all-ones score with index 0, learning never starts a search, the running best score never grows within a search, and no accumulator carries out of 18 bits. The bench's scenarios are needed for the rest. They show the real scores and winners against templates the bench chooses: exact recall of a learned slot, a known score of 150, ties inside one group, the largest possible score, and replacement of an overwritten slot. They also show the exact 290-cycle latency, and that bins sent during a search leave the bin count of the next histogram unchanged.

// File: rtl/hsm_pkg.sv
package hsm_pkg;
  // scan controller states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_DRAIN = 2'd2
  } scan_state_t;
endpackage

// File: rtl/hsm_sdp_ram.sv
// Simple dual-port memory: one write port, one registered read port.
module hsm_sdp_ram #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 36,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/hsm_lane_acc.sv
// One scoring lane: accumulates |a-b| over the bins of one group pass.
module hsm_lane_acc #(
  parameter int BIN_W = 12,
  parameter int ACC_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             first,
  input  logic [BIN_W-1:0] a,
  input  logic [BIN_W-1:0] b,
  output logic [ACC_W-1:0] acc
);
  logic [BIN_W-1:0] diff;
  logic [ACC_W:0]   nxt;

  assign diff = (a >= b) ? (a - b) : (b - a);
  assign nxt  = {1'b0, acc} + (ACC_W + 1)'(diff);

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else if (step) acc <= first ? ACC_W'(diff) : nxt[ACC_W-1:0];
  end

  // R2: the running sum never carries past the accumulator width
  p_acc_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    (step && !first) |-> !nxt[ACC_W]);
endmodule

// File: rtl/hsm_argmin.sv
// Folds one group of lane scores into the running best; lower index wins ties.
module hsm_argmin #(
  parameter int LANES  = 4,
  parameter int ACC_W  = 18,
  parameter int BANK_W = 3,
  localparam int LANE_W = $clog2(LANES),
  localparam int SLOT_W = BANK_W + LANE_W
) (
  input  logic [BANK_W-1:0]           bank,
  input  logic [LANES-1:0][ACC_W-1:0] lane_acc,
  input  logic [LANES-1:0]            lane_ok,
  input  logic                        in_found,
  input  logic [ACC_W-1:0]            in_sad,
  input  logic [SLOT_W-1:0]           in_idx,
  output logic                        out_found,
  output logic [ACC_W-1:0]            out_sad,
  output logic [SLOT_W-1:0]           out_idx
);
  always_comb begin
    out_found = in_found;
    out_sad   = in_sad;
    out_idx   = in_idx;
    for (int l = 0; l < LANES; l++) begin
      if (lane_ok[l] && (!out_found || lane_acc[l] < out_sad)) begin
        out_found = 1'b1;
        out_sad   = lane_acc[l];
        out_idx   = {bank, LANE_W'(l)};
      end
    end
  end
endmodule

// File: rtl/hist_sad_matcher.sv
module hist_sad_matcher
  import hsm_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int LANES     = 4,
  parameter int NUM_BINS  = 36,
  parameter int BIN_W     = 12,
  parameter int ACC_W     = 18,
  localparam int SLOT_W   = $clog2(NUM_BANKS * LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bin_valid,
  input  logic [BIN_W-1:0]  bin_data,
  input  logic              learn_in,
  input  logic [SLOT_W-1:0] slot_in,
  output logic              busy,
  output logic              done,
  output logic              no_match,
  output logic [SLOT_W-1:0] match_idx,
  output logic [ACC_W-1:0]  match_sad
);
  localparam int NUM_SLOTS = NUM_BANKS * LANES;
  localparam int LANE_W    = $clog2(LANES);
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int BINC_W    = $clog2(NUM_BINS);
  localparam int DEPTH     = NUM_BANKS * NUM_BINS;
  localparam int ADDR_W    = $clog2(DEPTH);
  localparam logic [BINC_W-1:0] LAST_BIN  = BINC_W'(NUM_BINS - 1);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

  scan_state_t state;

  // input side
  logic [BINC_W-1:0] bin_cnt;
  logic              learn_q;
  logic [SLOT_W-1:0] slot_q;
  logic              bin_take, first_bin, last_bin, cur_learn;
  logic [SLOT_W-1:0] cur_slot;
  logic [ADDR_W-1:0] wr_addr;
  logic [NUM_SLOTS-1:0] slot_ok;

  // scan side
  logic [BANK_W-1:0] rd_bank;
  logic [BINC_W-1:0] rd_bin;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_en;
  logic              s1_vld, s1_first, s1_last;
  logic [BANK_W-1:0] s1_bank;
  logic              cmp_go;
  logic [BANK_W-1:0] cmp_bank;
  logic [BIN_W-1:0]  hist_q;

  // search state
  logic              best_found, new_found;
  logic [ACC_W-1:0]  best_sad, new_sad;
  logic [SLOT_W-1:0] best_idx, new_idx;
  logic [LANES-1:0][ACC_W-1:0] lane_acc;
  logic [LANES-1:0]            lane_ok;

  assign bin_take  = bin_valid && (state == ST_IDLE);
  assign first_bin = (bin_cnt == '0);
  assign last_bin  = (bin_cnt == LAST_BIN);
  assign cur_learn = first_bin ? learn_in : learn_q;
  assign cur_slot  = first_bin ? slot_in  : slot_q;
  assign wr_addr   = ADDR_W'(cur_slot[SLOT_W-1:LANE_W]) * ADDR_W'(NUM_BINS) + ADDR_W'(bin_cnt);
  assign rd_addr   = ADDR_W'(rd_bank) * ADDR_W'(NUM_BINS) + ADDR_W'(rd_bin);
  assign rd_en     = (state == ST_SCAN);
  assign busy      = (state != ST_IDLE);

  // local copy of the incoming histogram, replayed once per group
  hsm_sdp_ram #(.WIDTH(BIN_W), .DEPTH(NUM_BINS)) u_hbuf (
    .clk   (clk),
    .we    (bin_take),
    .waddr (bin_cnt),
    .wdata (bin_data),
    .re    (rd_en),
    .raddr (rd_bin),
    .rdata (hist_q)
  );

  // one template store and one scoring lane per slot position in a group
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic             lane_we;
    logic [BIN_W-1:0] tmpl_q;

    assign lane_we = bin_take && cur_learn && (cur_slot[LANE_W-1:0] == LANE_W'(l));

    hsm_sdp_ram #(.WIDTH(BIN_W), .DEPTH(DEPTH)) u_tmpl (
      .clk   (clk),
      .we    (lane_we),
      .waddr (wr_addr),
      .wdata (bin_data),
      .re    (rd_en),
      .raddr (rd_addr),
      .rdata (tmpl_q)
    );

    hsm_lane_acc #(.BIN_W(BIN_W), .ACC_W(ACC_W)) u_acc (
      .clk   (clk),
      .rst   (rst),
      .step  (s1_vld),
      .first (s1_first),
      .a     (hist_q),
      .b     (tmpl_q),
      .acc   (lane_acc[l])
    );

    assign lane_ok[l] = slot_ok[{cmp_bank, LANE_W'(l)}];
  end

  hsm_argmin #(.LANES(LANES), .ACC_W(ACC_W), .BANK_W(BANK_W)) u_argmin (
    .bank      (cmp_bank),
    .lane_acc  (lane_acc),
    .lane_ok   (lane_ok),
    .in_found  (best_found),
    .in_sad    (best_sad),
    .in_idx    (best_idx),
    .out_found (new_found),
    .out_sad   (new_sad),
    .out_idx   (new_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bin_cnt    <= '0;
      learn_q    <= 1'b0;
      slot_q     <= '0;
      slot_ok    <= '0;
      rd_bank    <= '0;
      rd_bin     <= '0;
      s1_vld     <= 1'b0;
      s1_first   <= 1'b0;
      s1_last    <= 1'b0;
      s1_bank    <= '0;
      cmp_go     <= 1'b0;
      cmp_bank   <= '0;
      best_found <= 1'b0;
      best_sad   <= '1;
      best_idx   <= '0;
      done       <= 1'b0;
      no_match   <= 1'b0;
      match_idx  <= '0;
      match_sad  <= '0;
    end else begin
      // bin intake
      if (bin_take) begin
        if (first_bin) begin
          learn_q <= learn_in;
          slot_q  <= slot_in;
        end
        if (last_bin) begin
          bin_cnt <= '0;
          if (cur_learn) begin
            slot_ok[cur_slot] <= 1'b1;
          end else begin
            state      <= ST_SCAN;
            rd_bank    <= '0;
            rd_bin     <= '0;
            best_found <= 1'b0;
            best_sad   <= '1;
            best_idx   <= '0;
          end
        end else begin
          bin_cnt <= bin_cnt + BINC_W'(1);
        end
      end

      // read issue
      s1_vld   <= rd_en;
      s1_first <= (rd_bin == '0);
      s1_last  <= (rd_bin == LAST_BIN);
      s1_bank  <= rd_bank;
      if (rd_en) begin
        if (rd_bin == LAST_BIN) begin
          rd_bin <= '0;
          if (rd_bank == LAST_BANK) state <= ST_DRAIN;
          else rd_bank <= rd_bank + BANK_W'(1);
        end else begin
          rd_bin <= rd_bin + BINC_W'(1);
        end
      end

      // group compare and result post
      cmp_go   <= s1_vld && s1_last;
      cmp_bank <= s1_bank;
      done     <= 1'b0;
      if (cmp_go) begin
        best_found <= new_found;
        best_sad   <= new_sad;
        best_idx   <= new_idx;
        if (cmp_bank == LAST_BANK) begin
          done      <= 1'b1;
          no_match  <= !new_found;
          match_idx <= new_idx;
          match_sad <= new_sad;
          state     <= ST_IDLE;
        end
      end
    end
  end

  // R6: the result strobe lasts a single cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: a result only appears at the close of a busy period
  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  // R5: an empty search posts the all-ones score and index zero
  p_nomatch_out_r5: assert property (@(posedge clk) disable iff (rst)
    (done && no_match) |-> (match_sad == '1 && match_idx == '0));

  // R9: taking a learn bin never starts a search
  p_learn_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (bin_take && cur_learn) |=> !busy);

  // R3: the running best never gets worse within a search
  p_best_shrinks_r3: assert property (@(posedge clk) disable iff (rst)
    (cmp_go && best_found) |=> (best_found && best_sad <= $past(best_sad)));
endmodule

// File: tb/hist_sad_matcher_tb.sv
module hist_sad_matcher_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB    = 8;
  localparam int NBINS = 36;
  localparam int NSLOT = 32;
  localparam int AW    = 18;
  localparam int LAT   = NB * NBINS + 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bin_valid = 1'b0;
  logic [11:0] bin_data = '0;
  logic        learn_in = 1'b0;
  logic [4:0]  slot_in = '0;
  logic        busy, done, no_match;
  logic [4:0]  match_idx;
  logic [17:0] match_sad;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hist_sad_matcher u_dut (
    .clk       (clk),
    .rst       (rst),
    .bin_valid (bin_valid),
    .bin_data  (bin_data),
    .learn_in  (learn_in),
    .slot_in   (slot_in),
    .busy      (busy),
    .done      (done),
    .no_match  (no_match),
    .match_idx (match_idx),
    .match_sad (match_sad)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int tmpl [NSLOT][NBINS];
  bit tv   [NSLOT];
  int mh   [NBINS];
  int m_cnt, m_slot, m_wait;
  bit m_learn;
  bit e_done, e_busy, e_nm, p_nm;
  int e_idx, e_sad, p_idx, p_sad;

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSLOT; s++) tv[s] = 1'b0;
      m_cnt = 0; m_wait = 0; m_learn = 1'b0; m_slot = 0;
      e_done = 1'b0; e_busy = 1'b0; e_nm = 1'b0; e_idx = 0; e_sad = 0;
    end else begin
      e_done = 1'b0;
      if (m_wait > 0) begin
        m_wait--;
        if (m_wait == 0) begin
          e_done = 1'b1; e_busy = 1'b0;
          e_idx = p_idx; e_sad = p_sad; e_nm = p_nm;
        end
      end else if (bin_valid) begin
        if (m_cnt == 0) begin
          m_learn = learn_in;
          m_slot  = int'(slot_in);
        end
        mh[m_cnt] = int'(bin_data);
        m_cnt++;
        if (m_cnt == NBINS) begin
          m_cnt = 0;
          if (m_learn) begin
            for (int b = 0; b < NBINS; b++) tmpl[m_slot][b] = mh[b];
            tv[m_slot] = 1'b1;
          end else begin
            p_nm = 1'b1; p_sad = (1 << AW) - 1; p_idx = 0;
            for (int s = 0; s < NSLOT; s++) begin
              if (tv[s]) begin
                int sum;
                sum = 0;
                for (int b = 0; b < NBINS; b++)
                  sum += (mh[b] > tmpl[s][b]) ? mh[b] - tmpl[s][b] : tmpl[s][b] - mh[b];
                if (p_nm || sum < p_sad) begin
                  p_nm = 1'b0; p_sad = sum; p_idx = s;
                end
              end
            end
            m_wait = LAT;
            e_busy = 1'b1;
          end
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(done === e_done,       "R6 done timing",     int'(done),      int'(e_done));
      chk(busy === e_busy,       "R7 busy window",     int'(busy),      int'(e_busy));
      chk(no_match === e_nm,     "R5 no_match",        int'(no_match),  int'(e_nm));
      chk(int'(match_idx) == e_idx, "R3 winning slot", int'(match_idx), e_idx);
      chk(int'(match_sad) == e_sad, "R2 winning score", int'(match_sad), e_sad);
    end
  end

  // ---------------- stimulus ----------------
  int hv [NBINS];

  task automatic fill(input int seed);
    for (int b = 0; b < NBINS; b++) hv[b] = (seed * 523 + b * b * 29 + b * 71) % 4096;
  endtask

  task automatic send(input bit lrn, input int slot);
    for (int b = 0; b < NBINS; b++) begin
      @(negedge clk);
      bin_valid = 1'b1;
      bin_data  = hv[b][11:0];
      learn_in  = (b == 0) ? lrn : !lrn;
      slot_in   = 5'((b == 0) ? slot : slot ^ 3);
    end
    @(negedge clk);
    bin_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (LAT + 4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    chk(done == 1'b0,      "R8 reset done",     int'(done), 0);
    chk(busy == 1'b0,      "R8 reset busy",     int'(busy), 0);
    chk(no_match == 1'b0,  "R8 reset no_match", int'(no_match), 0);
    chk(match_idx == 5'd0, "R8 reset index",    int'(match_idx), 0);
    chk(match_sad == 18'd0,"R8 reset score",    int'(match_sad), 0);

    // R5/R8: empty library
    fill(1); send(1'b0, 0); settle();
    chk(no_match == 1'b1, "R5 R8 empty library", int'(no_match), 1);
    chk(match_sad == 18'h3FFFF, "R5 empty score", int'(match_sad), 262143);

    // R1/R9: learn three signatures
    fill(3); send(1'b1, 5);
    chk(busy == 1'b0, "R9 learn keeps idle", int'(busy), 0);
    fill(7); send(1'b1, 17);
    fill(11); send(1'b1, 30);
    repeat (4) @(negedge clk);
    chk(done == 1'b0, "R9 learn gives no done", int'(done), 0);

    fill(3); send(1'b0, 0); settle();
    chk(match_idx == 5'd5 && match_sad == 18'd0, "R1 exact recall slot 5", int'(match_idx), 5);

    // R2/R3: known distance of 150 from slot 17, with latency measurement for R6
    fill(7);
    hv[4]  = (hv[4]  >= 100) ? hv[4]  - 100 : hv[4]  + 100;
    hv[20] = (hv[20] >= 50)  ? hv[20] - 50  : hv[20] + 50;
    send(1'b0, 0);
    begin
      int n;
      n = 0;
      while (!done && n < LAT + 20) begin
        @(negedge clk);
        n++;
      end
      chk(n == LAT, "R6 latency", n, LAT);
      @(negedge clk);
      chk(done == 1'b0, "R6 single pulse", int'(done), 0);
      chk(match_sad == 18'd150, "R6 result holds", int'(match_sad), 150);
    end
    chk(match_idx == 5'd17, "R3 nearest slot", int'(match_idx), 17);
    chk(match_sad == 18'd150, "R2 score of 150", int'(match_sad), 150);

    // R4: ties inside one group and across groups
    fill(13); send(1'b1, 26); send(1'b1, 14); send(1'b1, 13);
    send(1'b0, 0); settle();
    chk(match_idx == 5'd13 && match_sad == 18'd0, "R4 tie goes to lower index", int'(match_idx), 13);

    // R7: bins sent during a search are ignored
    fill(7); send(1'b0, 0);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      bin_valid = 1'b1;
      bin_data  = 12'(k * 97);
      learn_in  = 1'b1;
      slot_in   = 5'd0;
    end
    @(negedge clk);
    bin_valid = 1'b0;
    settle();
    chk(match_idx == 5'd17 && match_sad == 18'd0, "R7 search unaffected", int'(match_idx), 17);
    fill(21); send(1'b1, 0); send(1'b0, 0); settle();
    chk(match_idx == 5'd0 && match_sad == 18'd0, "R7 next count starts fresh", int'(match_idx), 0);

    // R9: overwrite a used slot
    fill(40); send(1'b1, 5);
    fill(3); send(1'b0, 0); settle();
    chk(!(match_idx == 5'd5 && match_sad == 18'd0), "R9 old signature gone", int'(match_sad), 1);
    fill(40); send(1'b0, 0); settle();
    chk(match_idx == 5'd5 && match_sad == 18'd0, "R9 new signature found", int'(match_idx), 5);

    // R2: largest score, after a fresh reset
    do_reset();
    for (int b = 0; b < NBINS; b++) hv[b] = 0;
    send(1'b1, 31);
    for (int b = 0; b < NBINS; b++) hv[b] = 4095;
    send(1'b0, 0); settle();
    chk(match_idx == 5'd31, "R2 only slot 31", int'(match_idx), 31);
    chk(match_sad == 18'd147420, "R2 largest score", int'(match_sad), 147420);
    chk(no_match == 1'b0, "R5 match present", int'(no_match), 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule